// File: doc/BRIEF.md
# Edge/Level Interrupt Aggregator

This block collects a bank of interrupt source lines and folds them onto a larger bank of parent interrupt lines. Each source can be configured as level sensitive or edge sensitive. For every source the block keeps three bits of state: a request bit that records that the source has asked for service, an in-service bit that records that the request has been forwarded to a parent, and a mask bit. A per-source 8-bit routing entry chooses which parent line the source drives.

A register decoder outside the block delivers full-width command strobes: a new mask, a new edge-select pattern, a write-one-to-clear pattern and single routing-entry writes. The block drives the parent lines and presents a status vector of in-service sources that are not masked. Every change is handled through one of two evaluations. A promotion evaluation takes the lowest-indexed candidate that is requesting and unmasked, marks it in service and raises its parent line. A retirement evaluation takes the lowest-indexed candidate that is in service but no longer requesting, clears its in-service bit and lowers its parent line. Source transitions are sampled on the clock and handled one per cycle.

Top module: `irq_aggregator`

## Requirements
- R1: After reset every parent line is low, status is all zero, every source is masked, every source is level sensitive and every routing entry is 0. A source that requests while masked raises neither a parent line nor a status bit.
- R2: A level-sensitive source's request bit follows its input. When an unmasked level source rises it is put in service and its parent line goes high in the next cycle. When it falls it is retired and its parent line goes low.
- R3: An edge-sensitive source sets its request bit only on a low-to-high transition of its input. A later fall leaves the request and the in-service state in place. An input that stays high after a clear does not request again until it has gone low and risen once more.
- R4: The parent line driven by a source is the one whose index equals that source's 8-bit routing entry. A routing write stores `vec_wdata` into entry `vec_idx`.
- R5: `status` equals the in-service vector with the masked bits removed.
- R6: A mask write promotes the lowest-indexed newly unmasked source that is requesting. It retires the lowest-indexed newly masked source that is in service and no longer requesting. A newly masked source that is still requesting stays in service and keeps its parent line high.
- R7: A clear write acts only on edge-sensitive sources. For those sources it drops the request bits and the in-service bits. Clear bits that point at level-sensitive sources have no effect.
- R8: When a clear covers several in-service edge sources, only the lowest-indexed one has its parent line lowered. All of them leave the in-service state.
- R9: At most one source transition is processed per clock, lowest index first. A clear or mask write uses its cycle and defers source transitions to later cycles. Clear and mask writes must not arrive in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_in | input | NUM_SRC | Raw source lines, sampled on the clock |
| mask_we | input | 1 | Load a new mask vector |
| mask_wdata | input | NUM_SRC | New mask, 1 = masked |
| edge_we | input | 1 | Load a new trigger-mode vector |
| edge_wdata | input | NUM_SRC | Trigger mode, 1 = edge, 0 = level |
| clr_we | input | 1 | Apply a write-one clear pattern |
| clr_wdata | input | NUM_SRC | Sources to clear |
| vec_we | input | 1 | Write one routing entry |
| vec_idx | input | IDX_W | Routing entry index |
| vec_wdata | input | VEC_W | Parent line index for that source |
| parent_irq | output | 2**VEC_W | Parent interrupt lines |
| status | output | NUM_SRC | In-service and unmasked sources |

## Verification
The hardest state to reach from the ports is a parent line left high after its sources have already left service. This happens when one clear retires several edge sources at once. To set it up, the stimulus first brings several edge sources into service on their own parents while their inputs are still held high. It then issues one clear that covers all of them. Finally it checks that only the lowest-indexed source's parent line went low and that the held-high inputs do not request again. The same table also covers the masked-but-still-requesting case and a batch of simultaneous transitions, which must be handled in index order one cycle at a time.

// File: rtl/irq_aggr_pkg.sv
package irq_aggr_pkg;

    localparam int DEF_NUM_SRC = 64;
    localparam int DEF_VEC_W   = 8;

    // What the current cycle is spent on; commands outrank source transitions.
    typedef enum logic [1:0] {
        OP_IDLE,
        OP_SOURCE,
        OP_MASK,
        OP_CLEAR
    } aggr_op_e;

    // Sampled view of the source transition picked this cycle.
    typedef struct packed {
        logic level;
        logic edge_mode;
    } src_evt_t;

    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/irq_aggr_lowest.sv
module irq_aggr_lowest #(
    parameter  int W  = 64,
    localparam int IW = (W > 1) ? $clog2(W) : 1
) (
    input  logic [W-1:0]  req,
    output logic          found,
    output logic [IW-1:0] idx
);

    always_comb begin
        found = |req;
        idx   = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (req[i]) idx = IW'(i);
        end
    end

endmodule

// File: rtl/irq_aggr_vec_table.sv
module irq_aggr_vec_table #(
    parameter int N  = 64,
    parameter int VW = 8,
    parameter int IW = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [IW-1:0] widx,
    input  logic [VW-1:0] wdata,
    input  logic [IW-1:0] ridx_a,
    input  logic [IW-1:0] ridx_b,
    output logic [VW-1:0] rdata_a,
    output logic [VW-1:0] rdata_b
);

    logic [VW-1:0] entry_q [N];

    for (genvar g = 0; g < N; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst) begin
                entry_q[g] <= '0;
            end else if (we && widx == IW'(g)) begin
                entry_q[g] <= wdata;
            end
        end
    end

    assign rdata_a = entry_q[ridx_a];
    assign rdata_b = entry_q[ridx_b];

endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
    import irq_aggr_pkg::*;
#(
    parameter  int NUM_SRC = DEF_NUM_SRC,
    parameter  int VEC_W   = DEF_VEC_W,
    localparam int IDX_W   = idx_width(NUM_SRC),
    localparam int NUM_PAR = 1 << VEC_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] src_in,
    input  logic               mask_we,
    input  logic [NUM_SRC-1:0] mask_wdata,
    input  logic               edge_we,
    input  logic [NUM_SRC-1:0] edge_wdata,
    input  logic               clr_we,
    input  logic [NUM_SRC-1:0] clr_wdata,
    input  logic               vec_we,
    input  logic [IDX_W-1:0]   vec_idx,
    input  logic [VEC_W-1:0]   vec_wdata,
    output logic [NUM_PAR-1:0] parent_irq,
    output logic [NUM_SRC-1:0] status
);

    logic [NUM_SRC-1:0] pend_q, isr_q, last_q, mask_q, edge_q;
    logic [NUM_SRC-1:0] pend_n, isr_n, last_n, mask_n;
    logic [NUM_PAR-1:0] par_q, par_n;

    logic [NUM_SRC-1:0] diff, clr_eff, ev_onehot;
    logic [NUM_SRC-1:0] a_set, d_set, a_req, d_req;
    logic               ev_found, a_found, d_found;
    logic [IDX_W-1:0]   ev_idx, a_idx, d_idx;
    logic [VEC_W-1:0]   a_vec, d_vec;
    aggr_op_e           op;
    src_evt_t           evt;

    // Lowest-index pickers: pending transition, promotion, retirement.
    assign diff = src_in ^ last_q;

    irq_aggr_lowest #(.W(NUM_SRC)) u_ev (.req(diff),  .found(ev_found), .idx(ev_idx));
    irq_aggr_lowest #(.W(NUM_SRC)) u_as (.req(a_req), .found(a_found),  .idx(a_idx));
    irq_aggr_lowest #(.W(NUM_SRC)) u_ds (.req(d_req), .found(d_found),  .idx(d_idx));

    irq_aggr_vec_table #(.N(NUM_SRC), .VW(VEC_W), .IW(IDX_W)) u_tbl (
        .clk     (clk),
        .rst     (rst),
        .we      (vec_we),
        .widx    (vec_idx),
        .wdata   (vec_wdata),
        .ridx_a  (a_idx),
        .ridx_b  (d_idx),
        .rdata_a (a_vec),
        .rdata_b (d_vec)
    );

    always_comb begin
        if (clr_we)        op = OP_CLEAR;
        else if (mask_we)  op = OP_MASK;
        else if (ev_found) op = OP_SOURCE;
        else               op = OP_IDLE;
    end

    assign evt.level     = src_in[ev_idx];
    assign evt.edge_mode = edge_q[ev_idx];
    assign clr_eff       = clr_wdata & edge_q;
    assign ev_onehot     = NUM_SRC'(1) << ev_idx;

    // Request / history / mask update and the candidate sets for evaluation.
    always_comb begin
        pend_n = pend_q;
        last_n = last_q;
        mask_n = mask_q;
        a_set  = '0;
        d_set  = '0;
        unique case (op)
            OP_SOURCE: begin
                last_n[ev_idx] = evt.level;
                if (!evt.edge_mode)  pend_n[ev_idx] = evt.level;
                else if (evt.level)  pend_n[ev_idx] = 1'b1;
                if (evt.level) a_set = ev_onehot;
                else           d_set = ev_onehot;
            end
            OP_MASK: begin
                mask_n = mask_wdata;
                a_set  = mask_q & ~mask_wdata;
                d_set  = ~mask_q & mask_wdata;
            end
            OP_CLEAR: begin
                pend_n = pend_q & ~clr_eff;
                d_set  = clr_eff;
            end
            default: ;
        endcase
    end

    assign a_req = a_set & pend_n & ~mask_n;
    assign d_req = d_set & isr_q & ~pend_n;

    always_comb begin
        isr_n = isr_q;
        par_n = par_q;
        if (a_found) begin
            isr_n[a_idx] = 1'b1;
            par_n[a_vec] = 1'b1;
        end
        if (d_found) begin
            isr_n[d_idx] = 1'b0;
            par_n[d_vec] = 1'b0;
        end
        if (op == OP_CLEAR) isr_n = isr_n & ~clr_eff;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
            isr_q  <= '0;
            last_q <= '0;
            mask_q <= '1;
            edge_q <= '0;
            par_q  <= '0;
        end else begin
            pend_q <= pend_n;
            isr_q  <= isr_n;
            last_q <= last_n;
            mask_q <= mask_n;
            par_q  <= par_n;
            if (edge_we) edge_q <= edge_wdata;
        end
    end

    assign parent_irq = par_q;
    assign status     = isr_q & ~mask_q;

    AST_CMD_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(mask_we && clr_we)) else $error("mask and clear in one cycle"); // R9

    AST_ONE_EVENT: assert property (@(posedge clk) disable iff (rst)
        $countones(last_q ^ $past(last_q)) <= 1) else $error("two transitions in one cycle"); // R9

    AST_ONE_PROMOTE: assert property (@(posedge clk) disable iff (rst)
        $countones(isr_q & ~$past(isr_q)) <= 1) else $error("two promotions in one cycle"); // R9

    AST_EDGE_STICKY: assert property (@(posedge clk) disable iff (rst)
        !clr_we |=> ((($past(pend_q) & $past(edge_q)) & ~pend_q) == '0))
        else $error("edge request lost without clear"); // R3

    AST_LEVEL_CLR_IGNORED: assert property (@(posedge clk) disable iff (rst)
        clr_we |=> ((pend_q & ~$past(edge_q) & $past(clr_wdata))
                    == ($past(pend_q) & ~$past(edge_q) & $past(clr_wdata))))
        else $error("clear touched a level source"); // R7

    AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (par_q == '0 && mask_q == '1 && isr_q == '0))
        else $error("bad state after reset"); // R1

endmodule

// File: tb/irq_aggregator_test.sv
module irq_aggregator_test;

    localparam int CLK_PERIOD = 10;
    localparam int NS = 64;
    localparam int VW = 8;
    localparam int NP = 1 << VW;
    localparam int STEPS = 13;

    // {req, src[7:0], clr[7:0], exp_status[7:0], exp_parent[15:8]}
    // Sources 0..3 level (R2), 4..7 edge (R3); entry i routed to parent i+8 (R4).
    localparam logic [35:0] TBL [STEPS] = '{
        {4'd2, 8'h01, 8'h00, 8'h01, 8'h01},  // R2 level rise
        {4'd2, 8'h00, 8'h00, 8'h00, 8'h00},  // R2 level fall
        {4'd3, 8'h10, 8'h00, 8'h10, 8'h10},  // R3 edge rise
        {4'd3, 8'h00, 8'h00, 8'h10, 8'h10},  // R3 fall keeps request
        {4'd7, 8'h00, 8'h10, 8'h00, 8'h00},  // R7 edge clear
        {4'd4, 8'h32, 8'h00, 8'h32, 8'h32},  // R4 distinct parents
        {4'd7, 8'h32, 8'h02, 8'h32, 8'h32},  // R7 level clear ignored
        {4'd2, 8'h30, 8'h00, 8'h30, 8'h30},  // R2 level retire
        {4'd8, 8'h30, 8'h30, 8'h00, 8'h20},  // R8 multi clear, held high
        {4'd3, 8'h00, 8'h00, 8'h00, 8'h20},  // R3 no re-request on fall
        {4'd9, 8'hFF, 8'h00, 8'hFF, 8'hFF},  // R9 batch of transitions
        {4'd8, 8'hFF, 8'hF0, 8'h0F, 8'hEF},  // R8 multi clear
        {4'd2, 8'h00, 8'h00, 8'h00, 8'hE0}   // R2 level retire batch
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NS-1:0] src_in = '0;
    logic          mask_we = 1'b0, edge_we = 1'b0, clr_we = 1'b0, vec_we = 1'b0;
    logic [NS-1:0] mask_wdata = '0, edge_wdata = '0, clr_wdata = '0;
    logic [5:0]    vec_idx = '0;
    logic [VW-1:0] vec_wdata = '0;
    logic [NP-1:0] parent_irq;
    logic [NS-1:0] status;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    irq_aggregator uut (
        .clk(clk), .rst(rst), .src_in(src_in),
        .mask_we(mask_we), .mask_wdata(mask_wdata),
        .edge_we(edge_we), .edge_wdata(edge_wdata),
        .clr_we(clr_we), .clr_wdata(clr_wdata),
        .vec_we(vec_we), .vec_idx(vec_idx), .vec_wdata(vec_wdata),
        .parent_irq(parent_irq), .status(status)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        tick(3);
        rst = 1'b0;
    endtask

    task automatic set_vec(input int idx, input int val);
        vec_we = 1'b1; vec_idx = 6'(idx); vec_wdata = VW'(val);
        tick(1);
        vec_we = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        tick(1);
        do_reset();
        chk("R1 parents low after reset", 64'(|parent_irq), 64'd0);
        chk("R1 status zero after reset", status, 64'd0);

        // Masked at reset: level source 0 requests but stays quiet.
        src_in[0] = 1'b1;
        tick(3);
        chk("R1 masked source silent", 64'(parent_irq[0]), 64'd0);
        chk("R1 masked status", status, 64'd0);

        // Unmask source 0: promotion on mask write (entry 0 = parent 0).
        mask_we = 1'b1; mask_wdata = ~64'h1;
        tick(1);
        mask_we = 1'b0;
        chk("R6 unmask promotes", 64'(parent_irq[0]), 64'd1);
        chk("R5 status after unmask", status, 64'h1);

        // Mask again while still requesting: stays in service.
        mask_we = 1'b1; mask_wdata = '1;
        tick(1);
        mask_we = 1'b0;
        chk("R6 masked but requesting keeps parent", 64'(parent_irq[0]), 64'd1);
        chk("R5 status hides masked", status, 64'd0);

        src_in[0] = 1'b0;
        tick(2);
        chk("R2 level fall retires", 64'(parent_irq[0]), 64'd0);

        // Table setup.
        do_reset();
        for (int i = 0; i < 8; i++) set_vec(i, i + 8);
        mask_we = 1'b1; mask_wdata = ~64'hFF;
        edge_we = 1'b1; edge_wdata = 64'hF0;
        tick(1);
        mask_we = 1'b0; edge_we = 1'b0;

        for (int k = 0; k < STEPS; k++) begin
            logic [35:0] e;
            e = TBL[k];
            if (e[23:16] != 8'h00) begin
                clr_we = 1'b1; clr_wdata = {56'd0, e[23:16]};
                tick(1);
                clr_we = 1'b0;
            end
            src_in[7:0] = e[31:24];
            tick(10);
            chk($sformatf("R%0d step %0d status", e[35:32], k), 64'(status[7:0]), 64'(e[15:8]));
            chk($sformatf("R%0d step %0d parents", e[35:32], k), 64'(parent_irq[15:8]), 64'(e[7:0]));
        end

        // R9: two level sources rise together, handled lowest first.
        set_vec(8, 31);
        set_vec(9, 30);
        mask_we = 1'b1; mask_wdata = ~64'h3FF;
        tick(1);
        mask_we = 1'b0;
        src_in[9:8] = 2'b11;
        tick(1);
        chk("R9 first cycle status", 64'(status[9:8]), 64'h1);
        chk("R9 first cycle parents", 64'(parent_irq[31:30]), 64'h2);
        tick(1);
        chk("R9 second cycle status", 64'(status[9:8]), 64'h3);
        chk("R9 second cycle parents", 64'(parent_irq[31:30]), 64'h3);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule